// File: doc/BRIEF.md
# MESI L1 Coherence Agent

This block holds the coherence state of every line in a small private L1 and decides, for each core operation, whether it can finish locally or must ask the home node. The core presents a load, a read-for-ownership or a store against a line index and holds it until `op_done` rises. A hit finishes in the same cycle. A miss raises one request on the outbound port, and the operation then stalls until the home node's reply has put the line into a state where it can finish.

Inbound commands from the home node grant a line with data (shared, exclusive or modified), promote a shared line to modified, downgrade a modified or exclusive line to shared, invalidate a clean copy or evict a dirty one. Downgrading or evicting a dirty line returns its word on the request port in the same cycle. Tag and data arrays, replacement and the ring transport sit outside the block. Each line's payload is a single word of `WORD_W` bits.

Top module: `mesi_l1_agent`

## Requirements
- R1: After reset every line is Invalid, and with no operation presented `op_done`, `op_stall` and `req_valid` are all low.
- R2: Operation codes are 0 load, 1 read-for-ownership, 2 store. A miss raises `req_valid` for one cycle with `req_line` set to the line and `req_opcode` set to 0 (shared read) for a load, 1 (ownership read) for a read-for-ownership and 2 (store request) for a store. A load misses only in Invalid. The other two miss in Shared or Invalid.
- R3: Command codes 0, 1 and 2 install the line in Shared, Exclusive and Modified respectively, and load `cmd_data` as its word. After code 2, a held store completes.
- R4: A store to an Exclusive line completes in the cycle it is presented, sends no request, writes `op_wdata`, and leaves the line Modified.
- R5: After a miss request, no further request is raised for the held operation, and `op_stall` stays high until it completes.
- R6: Command 4 (downgrade) on a Modified line raises `req_valid` with opcode 3 (writeback, keep shared) and the line's word in the same cycle, and leaves the line Shared.
- R7: Command 4 on an Exclusive line leaves it Shared and raises no request.
- R8: Command 5 (invalidate) moves a Shared or Exclusive line to Invalid with no request. Command 6 (evict) on a Modified line raises opcode 4 (writeback, drop) with the word and moves it to Invalid.
- R9: If a store is waiting and its line is invalidated, no new request is raised, the store keeps stalling, and it completes after command 2 arrives.
- R10: Command 3 (ownership grant) moves a Shared line to Modified and keeps its word, so a waiting store then completes.
- R11: In a cycle with `cmd_valid` high, no core operation completes or raises a request.
- R12: A hit completes in the cycle it is presented, sends no request, and shows the line's word on `op_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Core operation presented and held until done |
| op_kind | input | 2 | 0 load, 1 read-for-ownership, 2 store |
| op_line | input | IDX_W | Line index of the operation |
| op_wdata | input | WORD_W | Store word |
| op_done | output | 1 | Operation completes this cycle |
| op_stall | output | 1 | Operation presented but not completing |
| op_rdata | output | WORD_W | Word of the addressed line |
| req_valid | output | 1 | Outbound message valid |
| req_opcode | output | 3 | 0 shared read, 1 ownership read, 2 store, 3 writeback keep, 4 writeback drop |
| req_line | output | IDX_W | Line of the outbound message |
| req_data | output | WORD_W | Writeback word (zero for requests) |
| cmd_valid | input | 1 | Inbound command valid |
| cmd_opcode | input | 3 | 0 data shared, 1 data exclusive, 2 data modified, 3 ownership grant, 4 downgrade, 5 invalidate, 6 evict |
| cmd_line | input | IDX_W | Line of the command |
| cmd_data | input | WORD_W | Word carried by data commands |

## Verification
Every operation kind is tried against every starting state, with that state set up by the matching command. This separates which combinations finish locally from which raise which request, and it shows that a held miss neither repeats its request nor completes during the command cycle. Directed sequences then tell Modified apart from Exclusive by whether a downgrade returns a word, and Shared apart from Invalid by whether a load misses. They also cover the race in which a waiting store loses its copy and still completes on its own grant, and check that a promoted Shared line keeps the word written after promotion.

// File: rtl/mesi_agent_pkg.sv
package mesi_agent_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_RFO   = 2'd1,
        OP_STORE = 2'd2,
        OP_RSVD  = 2'd3
    } core_op_e;

    typedef enum logic [2:0] {
        REQ_RD_S  = 3'd0,
        REQ_RD_OWN = 3'd1,
        REQ_STORE = 3'd2,
        REQ_WB_KEEP = 3'd3,
        REQ_WB_DROP = 3'd4
    } req_op_e;

    typedef enum logic [2:0] {
        CMD_DATA_S   = 3'd0,
        CMD_DATA_E   = 3'd1,
        CMD_DATA_M   = 3'd2,
        CMD_GRANT_M  = 3'd3,
        CMD_DOWNGRADE = 3'd4,
        CMD_INVAL    = 3'd5,
        CMD_EVICT    = 3'd6,
        CMD_RSVD     = 3'd7
    } cmd_op_e;

endpackage

// File: rtl/mesi_op_decide.sv
module mesi_op_decide
    import mesi_agent_pkg::*;
(
    input  core_op_e kind,
    input  mesi_e    cur,
    output logic     hit,
    output mesi_e    nxt,
    output req_op_e  miss_req
);
    always_comb begin
        hit      = 1'b0;
        nxt      = cur;
        miss_req = REQ_RD_S;
        case (kind)
            OP_RFO: begin
                hit      = (cur == ST_E) || (cur == ST_M);
                miss_req = REQ_RD_OWN;
            end
            OP_STORE: begin
                hit      = (cur == ST_E) || (cur == ST_M);
                nxt      = ST_M;
                miss_req = REQ_STORE;
            end
            default: begin
                hit      = (cur != ST_I);
                miss_req = REQ_RD_S;
            end
        endcase
    end
endmodule

// File: rtl/mesi_cmd_react.sv
module mesi_cmd_react
    import mesi_agent_pkg::*;
(
    input  cmd_op_e cmd,
    input  mesi_e   cur,
    output mesi_e   nxt,
    output logic    take_data,
    output logic    wb,
    output req_op_e wb_op
);
    always_comb begin
        nxt       = cur;
        take_data = 1'b0;
        wb        = 1'b0;
        wb_op     = REQ_WB_KEEP;
        case (cmd)
            CMD_DATA_S: begin
                nxt       = ST_S;
                take_data = 1'b1;
            end
            CMD_DATA_E: begin
                nxt       = ST_E;
                take_data = 1'b1;
            end
            CMD_DATA_M: begin
                nxt       = ST_M;
                take_data = 1'b1;
            end
            CMD_GRANT_M: begin
                if (cur != ST_I) nxt = ST_M;
            end
            CMD_DOWNGRADE: begin
                if (cur == ST_M) begin
                    nxt   = ST_S;
                    wb    = 1'b1;
                    wb_op = REQ_WB_KEEP;
                end else if (cur == ST_E) begin
                    nxt = ST_S;
                end
            end
            CMD_INVAL: begin
                if ((cur == ST_S) || (cur == ST_E)) nxt = ST_I;
            end
            CMD_EVICT: begin
                nxt = ST_I;
                if (cur == ST_M) begin
                    wb    = 1'b1;
                    wb_op = REQ_WB_DROP;
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/mesi_l1_agent.sv
module mesi_l1_agent
    import mesi_agent_pkg::*;
#(
    parameter  int LINES  = 4,
    parameter  int WORD_W = 8,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [IDX_W-1:0]  op_line,
    input  logic [WORD_W-1:0] op_wdata,
    output logic              op_done,
    output logic              op_stall,
    output logic [WORD_W-1:0] op_rdata,
    output logic              req_valid,
    output logic [2:0]        req_opcode,
    output logic [IDX_W-1:0]  req_line,
    output logic [WORD_W-1:0] req_data,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_opcode,
    input  logic [IDX_W-1:0]  cmd_line,
    input  logic [WORD_W-1:0] cmd_data
);
    typedef struct packed {
        logic [LINES-1:0][1:0]        st;
        logic [LINES-1:0][WORD_W-1:0] word;
        logic                         pend;
    } agent_regs_t;

    agent_regs_t regs_d, regs_q;

    core_op_e kind;
    mesi_e    op_cur, op_nxt, cmd_cur, cmd_nxt;
    logic     op_hit, cmd_take, cmd_wb;
    req_op_e  op_req, cmd_wb_op;

    assign kind    = core_op_e'(op_kind);
    assign op_cur  = mesi_e'(regs_q.st[op_line]);
    assign cmd_cur = mesi_e'(regs_q.st[cmd_line]);

    mesi_op_decide decide_i (
        .kind     (kind),
        .cur      (op_cur),
        .hit      (op_hit),
        .nxt      (op_nxt),
        .miss_req (op_req)
    );

    mesi_cmd_react react_i (
        .cmd       (cmd_op_e'(cmd_opcode)),
        .cur       (cmd_cur),
        .nxt       (cmd_nxt),
        .take_data (cmd_take),
        .wb        (cmd_wb),
        .wb_op     (cmd_wb_op)
    );

    always_comb begin
        regs_d     = regs_q;
        op_done    = 1'b0;
        req_valid  = 1'b0;
        req_opcode = 3'd0;
        req_line   = '0;
        req_data   = '0;
        if (cmd_valid) begin
            regs_d.st[cmd_line] = cmd_nxt;
            if (cmd_take) regs_d.word[cmd_line] = cmd_data;
            if (cmd_wb) begin
                req_valid  = 1'b1;
                req_opcode = cmd_wb_op;
                req_line   = cmd_line;
                req_data   = regs_q.word[cmd_line];
            end
        end else if (op_valid) begin
            if (op_hit) begin
                op_done            = 1'b1;
                regs_d.st[op_line] = op_nxt;
                regs_d.pend        = 1'b0;
                if (kind == OP_STORE) regs_d.word[op_line] = op_wdata;
            end else if (!regs_q.pend) begin
                req_valid   = 1'b1;
                req_opcode  = op_req;
                req_line    = op_line;
                regs_d.pend = 1'b1;
            end
        end
    end

    assign op_stall = op_valid && !op_done;
    assign op_rdata = regs_q.word[op_line];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/mesi_l1_agent_chk.sv
module mesi_l1_agent_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_kind,
    input logic [IDX_W-1:0] op_line,
    input logic             op_done,
    input logic             req_valid,
    input logic [2:0]       req_opcode,
    input logic [IDX_W-1:0] req_line,
    input logic             cmd_valid,
    input logic [2:0]       cmd_opcode,
    input logic [IDX_W-1:0] cmd_line
);
    logic core_req;
    assign core_req = req_valid && !cmd_valid;

    // R11
    cmd_blocks_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !op_done);

    // R2
    miss_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && op_kind != 2'd3) |-> (req_opcode == {1'b0, op_kind} && req_line == op_line));

    // R5
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |=> !core_req);

    // R6
    downgrade_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == 3'd4 && req_valid) |-> (req_opcode == 3'd3 && req_line == cmd_line));

    // R8
    evict_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == 3'd6 && req_valid) |-> (req_opcode == 3'd4 && req_line == cmd_line));

    // R12
    hit_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !req_valid);
endmodule

bind mesi_l1_agent mesi_l1_agent_chk #(.IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_kind    (op_kind),
    .op_line    (op_line),
    .op_done    (op_done),
    .req_valid  (req_valid),
    .req_opcode (req_opcode),
    .req_line   (req_line),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_line   (cmd_line)
);

// File: tb/mesi_l1_agent_tb_top.sv
`timescale 1ns/1ps
module mesi_l1_agent_tb_top;
    localparam logic [2:0] C_DS = 3'd0, C_DE = 3'd1, C_DM = 3'd2, C_GM = 3'd3,
                           C_DN = 3'd4, C_IV = 3'd5, C_EV = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = '0;
    logic [1:0] op_line = '0;
    logic [7:0] op_wdata = '0;
    logic       op_done, op_stall;
    logic [7:0] op_rdata;
    logic       req_valid;
    logic [2:0] req_opcode;
    logic [1:0] req_line;
    logic [7:0] req_data;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_opcode = '0;
    logic [1:0] cmd_line = '0;
    logic [7:0] cmd_data = '0;

    int n_run = 0;
    int n_fail = 0;

    logic       c_done, c_stall, c_rv;
    logic [2:0] c_rop;
    logic [1:0] c_rline;
    logic [7:0] c_rdata, c_odata;

    always #5 clk = ~clk;

    mesi_l1_agent #(.LINES(4), .WORD_W(8)) dut_i (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        c_done = op_done; c_stall = op_stall; c_rv = req_valid;
        c_rop = req_opcode; c_rline = req_line; c_rdata = req_data; c_odata = op_rdata;
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic [2:0] o, input logic [1:0] l, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_opcode = o; cmd_line = l; cmd_data = d;
        cycle();
        cmd_valid = 1'b0;
    endtask

    task automatic set_state(input logic [1:0] l, input int s, input logic [7:0] d);
        case (s)
            0: cmd(C_EV, l, 8'h00);
            1: cmd(C_DS, l, d);
            2: cmd(C_DE, l, d);
            default: cmd(C_DM, l, d);
        endcase
    endtask

    task automatic present(input logic [1:0] k, input logic [1:0] l, input logic [7:0] w);
        op_valid = 1'b1; op_kind = k; op_line = l; op_wdata = w;
        cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset, then a load to any line misses
        cycle();
        chk("R1", "req_valid idle", c_rv, 0);
        chk("R1", "op_done idle", c_done, 0);
        chk("R1", "op_stall idle", c_stall, 0);
        present(2'd0, 2'd3, 8'h00);
        chk("R1", "load after reset done", c_done, 0);
        chk("R1", "load after reset opcode", c_rop, 0);
        cmd(C_DS, 2'd3, 8'h3C);
        cycle();
        chk("R3", "load done after shared data", c_done, 1);
        chk("R3", "shared word", c_odata, 8'h3C);
        op_valid = 1'b0;

        // R2 R3 R5 R11 R12: sweep every operation kind over every start state
        for (int k = 0; k < 3; k++) begin
            for (int s = 0; s < 4; s++) begin
                automatic logic [1:0] ln = 2'(s);
                automatic logic [7:0] dv = 8'(16 * k + s + 1);
                automatic bit eh = (k == 0) ? (s != 0) : (s >= 2);
                set_state(ln, s, dv);
                present(2'(k), ln, 8'hC0 + dv);
                chk("R2/R12", "done on first cycle", c_done, eh);
                if (eh) begin
                    chk("R12", "no message on hit", c_rv, 0);
                    if (k == 0) chk("R12", "hit word", c_odata, dv);
                end else begin
                    chk("R2", "req_valid on miss", c_rv, 1);
                    chk("R2", "miss opcode", c_rop, 3'(k));
                    chk("R2", "miss line", c_rline, ln);
                    cycle();
                    chk("R5", "no repeated request", c_rv, 0);
                    chk("R5", "still stalling", c_stall, 1);
                    cmd(C_DM, ln, dv + 8'h40);
                    chk("R11", "no completion in command cycle", c_done, 0);
                    cycle();
                    chk("R3", "done after modified grant", c_done, 1);
                    if (k == 0) chk("R3", "word after modified grant", c_odata, dv + 8'h40);
                end
                op_valid = 1'b0;
            end
        end

        // R4 R6: silent E->M, downgrade returns stored word
        cmd(C_DE, 2'd1, 8'h11);
        present(2'd2, 2'd1, 8'h5A);
        chk("R4", "store on exclusive done", c_done, 1);
        chk("R4", "store on exclusive silent", c_rv, 0);
        op_valid = 1'b0;
        cmd(C_DN, 2'd1, 8'h00);
        chk("R6", "downgrade writeback valid", c_rv, 1);
        chk("R6", "downgrade writeback opcode", c_rop, 3);
        chk("R6", "downgrade writeback word", c_rdata, 8'h5A);
        present(2'd0, 2'd1, 8'h00);
        chk("R6", "load hits after downgrade", c_done, 1);
        chk("R6", "word kept after downgrade", c_odata, 8'h5A);
        op_valid = 1'b0;

        // R10: store on shared line waits for ownership grant
        present(2'd2, 2'd1, 8'h77);
        chk("R10", "store on shared misses", c_done, 0);
        chk("R10", "store on shared opcode", c_rop, 2);
        cmd(C_GM, 2'd1, 8'h00);
        chk("R10", "grant raises no message", c_rv, 0);
        cycle();
        chk("R10", "store done after grant", c_done, 1);
        op_valid = 1'b0;
        cmd(C_DN, 2'd1, 8'h00);
        chk("R10", "promoted line returns stored word", c_rdata, 8'h77);

        // R7: downgrade of exclusive is silent and leaves it shared
        cmd(C_DE, 2'd2, 8'h22);
        cmd(C_DN, 2'd2, 8'h00);
        chk("R7", "exclusive downgrade silent", c_rv, 0);
        present(2'd2, 2'd2, 8'h23);
        chk("R7", "store after exclusive downgrade misses", c_done, 0);
        cmd(C_DM, 2'd2, 8'h33);
        cycle();
        chk("R7", "store completes after grant", c_done, 1);
        op_valid = 1'b0;

        // R8: invalidate clean, evict dirty
        cmd(C_DS, 2'd3, 8'h44);
        cmd(C_IV, 2'd3, 8'h00);
        chk("R8", "invalidate silent", c_rv, 0);
        present(2'd0, 2'd3, 8'h00);
        chk("R8", "load misses after invalidate", c_done, 0);
        chk("R8", "shared read after invalidate", c_rop, 0);
        cmd(C_DS, 2'd3, 8'h45);
        cycle();
        op_valid = 1'b0;
        cmd(C_DM, 2'd3, 8'h46);
        cmd(C_EV, 2'd3, 8'h00);
        chk("R8", "evict writeback valid", c_rv, 1);
        chk("R8", "evict writeback opcode", c_rop, 4);
        chk("R8", "evict writeback word", c_rdata, 8'h46);
        present(2'd0, 2'd3, 8'h00);
        chk("R8", "load misses after evict", c_done, 0);
        cmd(C_DS, 2'd3, 8'h47);
        cycle();
        op_valid = 1'b0;

        // R9: waiting store loses its copy, still completes on its own grant
        cmd(C_DS, 2'd0, 8'h50);
        present(2'd2, 2'd0, 8'h99);
        chk("R9", "store on shared requests", c_rop, 2);
        cmd(C_IV, 2'd0, 8'h00);
        chk("R9", "invalidate while waiting silent", c_rv, 0);
        cycle();
        chk("R9", "no new request after invalidate", c_rv, 0);
        chk("R9", "still stalling after invalidate", c_stall, 1);
        cmd(C_DM, 2'd0, 8'h51);
        cycle();
        chk("R9", "store done after grant", c_done, 1);
        op_valid = 1'b0;
        cmd(C_DN, 2'd0, 8'h00);
        chk("R9", "stored word written back", c_rdata, 8'h99);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule